// File: doc/BRIEF.md
# Feature access trap evaluator

This block decides, for one instruction or system-register access, whether a packed 64-bit access-control word forces a trap. It takes the current privilege level (0 to 3), the execution state (32-bit or 64-bit), a class code for the access, and a set of feature-present flags. It also takes three routing flags: the level-2 enable, the host flag (E2H) and the trap-general flag (TGE). It returns a trap flag, the privilege level that takes the trap, and a 6-bit exception class code.

The decision logic is combinational. Its result is captured in one output register, so the outputs show the decision for the inputs that were present at the previous rising clock edge. The control word holds three two-bit level-selective enables: floating-point/SIMD, vector and matrix. It also holds a single trace-trap bit and a single overlay-enable bit, which have opposite polarities. When more than one field could trap an access, a fixed precedence picks the field that reports.

Top module: `trap_eval`

## Requirements
- R1: Each two-bit enable (FP/SIMD at bits 21:20, vector at bits 17:16, matrix at bits 25:24) traps at levels 0 and 1 when 00 or 10, traps only level 0 when 01, and traps nothing when 11. An FP access is op class 1.
- R2: Bit 28 set to 1 traps level 0 and level 1 trace register accesses. The class code is 0x18 in 64-bit state. In 32-bit state it is 0x05 for a single transfer (op class 6) and 0x0C for a double transfer (op class 7).
- R3: A permission-overlay access (op class 8) from level 0 in 64-bit state traps with code 0x18 when bit 29 is 0. It does not trap when bit 29 is 1, when it comes from any other level, or when the overlay feature is absent.
- R4: A trap targets level 2 (target 2) when the level-2 enable and TGE are both 1. Otherwise it targets level 1 (target 1).
- R5: An FP-field trap reports code 0x07 when it targets level 1 and code 0x00 when it targets level 2.
- R6: At level 0, when E2H and TGE are both 1, no field causes a trap.
- R7: Accesses at levels 2 and 3 never trap.
- R8: For a vector instruction (op class 2) or a matrix instruction (op class 3), a trap from the vector or matrix field wins over an FP-field trap and reports 0x19 (vector) or 0x1D (matrix). The FP field is checked only when the governing field does not trap.
- R9: Vector instructions are governed by the matrix field when streaming mode is on or the vector feature is absent. Otherwise they are governed by the vector field.
- R10: An absent vector or matrix feature makes that field decode as 00. An absent trace feature disables the trace trap. Vector-control (op 4) and matrix-control (op 5) accesses use only their own field.
- R11: A level 0 trace access never traps when the flag for a trace unit that forbids level 0 access is set.
- R12: All bits outside 29:28, 25:24, 21:20 and 17:16 have no effect, including bits 31 and 30.
- R13: Outputs are registered with one cycle of latency and are all zero in reset. When there is no trap, the target and the class code are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_word_i | input | 64 | Packed access-control word |
| cur_el_i | input | 2 | Current privilege level |
| aarch32_i | input | 1 | 1 = 32-bit execution state |
| op_class_i | input | 4 | Access class: 0 none, 1 FP, 2 vector, 3 matrix, 4 vector ctrl, 5 matrix ctrl, 6 trace single, 7 trace double, 8 overlay |
| streaming_i | input | 1 | Streaming mode active |
| has_vec_i | input | 1 | Vector feature present |
| has_mat_i | input | 1 | Matrix feature present |
| has_trace_i | input | 1 | Trace register access present |
| has_ovl_i | input | 1 | Overlay register present |
| trace_no_el0_i | input | 1 | Trace unit forbids level 0 access |
| el2_en_i | input | 1 | Level 2 implemented and enabled |
| e2h_i | input | 1 | Host flag |
| tge_i | input | 1 | Trap-general flag |
| trap_o | output | 1 | Trap required |
| target_el_o | output | 2 | Level taking the trap |
| ec_o | output | 6 | Exception class code |

## Verification
The timed properties compare the outputs with the inputs of the previous cycle. They assume that the inputs are stable across each rising edge and that reset is released away from an edge. The bench meets this by changing every input only on the falling edge. The properties do not depend on whether a given combination of flags could occur on a real core. An example is TGE set while level 1 is running, and the bench does drive such combinations. Op class codes 9 to 15 are treated as no-access. The sweep produces only the codes 0 to 8.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CTRL_W = 64;
  localparam int EL_W   = 2;
  localparam int EC_W   = 6;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NONE    = 4'd0,
    OP_FP      = 4'd1,
    OP_VEC     = 4'd2,
    OP_MAT     = 4'd3,
    OP_VEC_CTL = 4'd4,
    OP_MAT_CTL = 4'd5,
    OP_TRC_SGL = 4'd6,
    OP_TRC_DBL = 4'd7,
    OP_OVL     = 4'd8
  } op_e;

  // level-selective two-bit fields
  localparam int FLD_FP  = 0;
  localparam int FLD_VEC = 1;
  localparam int FLD_MAT = 2;
  localparam int NUM_FLD = 3;

  localparam int TRC_BIT = 28;
  localparam int OVL_BIT = 29;

  function automatic int fld_lsb(input int idx);
    case (idx)
      FLD_FP:  return 20;
      FLD_VEC: return 16;
      default: return 24;
    endcase
  endfunction

  function automatic logic [CTRL_W-1:0] used_mask();
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_FLD; i++) m[fld_lsb(i) +: 2] = 2'b11;
    m[TRC_BIT] = 1'b1;
    m[OVL_BIT] = 1'b1;
    return m;
  endfunction

  localparam logic [EC_W-1:0] EC_SYSREG  = 6'h18;
  localparam logic [EC_W-1:0] EC_TRC_SGL = 6'h05;
  localparam logic [EC_W-1:0] EC_TRC_DBL = 6'h0C;
  localparam logic [EC_W-1:0] EC_MAT     = 6'h1D;
  localparam logic [EC_W-1:0] EC_VEC     = 6'h19;
  localparam logic [EC_W-1:0] EC_FP_L1   = 6'h07;
  localparam logic [EC_W-1:0] EC_FP_L2   = 6'h00;

  typedef struct packed {
    logic            trap;
    logic [EL_W-1:0] tgt;
    logic [EC_W-1:0] ec;
  } trap_res_t;
endpackage

// File: rtl/trap_fld_dec.sv
module trap_fld_dec
  import trap_pkg::*;
(
  input  logic [1:0]      fld_i,
  input  logic            present_i,
  input  logic [EL_W-1:0] el_i,
  output logic            trap_o
);
  logic [1:0] eff;
  assign eff = present_i ? fld_i : 2'b00;

  always_comb begin
    unique case (el_i)
      2'd0:    trap_o = (eff != 2'b11);
      2'd1:    trap_o = ~eff[0];
      default: trap_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
(
  input  logic [EL_W-1:0] el_i,
  input  logic            el2_en_i,
  input  logic            e2h_i,
  input  logic            tge_i,
  output logic            to_el2_o,
  output logic            suppress_o
);
  assign to_el2_o   = el2_en_i & tge_i;
  // host mode lifts all level-0 traps; levels 2/3 are outside this word
  assign suppress_o = ((el_i == 2'd0) & e2h_i & tge_i) | el_i[1];
endmodule

// File: rtl/trap_arb.sv
module trap_arb
  import trap_pkg::*;
(
  input  logic [NUM_FLD-1:0] fld_trap_i,
  input  logic [OP_W-1:0]    op_i,
  input  logic [EL_W-1:0]    el_i,
  input  logic               aarch32_i,
  input  logic               streaming_i,
  input  logic               has_vec_i,
  input  logic               trc_bit_i,
  input  logic               ovl_bit_i,
  input  logic               has_ovl_i,
  input  logic               trace_no_el0_i,
  input  logic               to_el2_i,
  input  logic               suppress_i,
  output trap_res_t          res_o
);
  logic            hit;
  logic [EC_W-1:0] code;
  logic [EC_W-1:0] fp_code;
  logic            gov_mat;
  logic            gov_trap;
  logic            trc_ok;
  op_e             op;

  assign op       = op_e'(op_i);
  assign fp_code  = to_el2_i ? EC_FP_L2 : EC_FP_L1;
  assign gov_mat  = streaming_i | ~has_vec_i;
  assign gov_trap = gov_mat ? fld_trap_i[FLD_MAT] : fld_trap_i[FLD_VEC];
  assign trc_ok   = trc_bit_i & ~el_i[1] & ~((el_i == 2'd0) & trace_no_el0_i);

  always_comb begin
    hit  = 1'b0;
    code = '0;
    case (op)
      OP_FP: begin
        hit  = fld_trap_i[FLD_FP];
        code = fp_code;
      end
      OP_VEC: begin
        if (gov_trap) begin
          hit  = 1'b1;
          code = gov_mat ? EC_MAT : EC_VEC;
        end else if (fld_trap_i[FLD_FP]) begin
          hit  = 1'b1;
          code = fp_code;
        end
      end
      OP_MAT: begin
        if (fld_trap_i[FLD_MAT]) begin
          hit  = 1'b1;
          code = EC_MAT;
        end else if (fld_trap_i[FLD_FP]) begin
          hit  = 1'b1;
          code = fp_code;
        end
      end
      OP_VEC_CTL: begin
        hit  = fld_trap_i[FLD_VEC];
        code = EC_VEC;
      end
      OP_MAT_CTL: begin
        hit  = fld_trap_i[FLD_MAT];
        code = EC_MAT;
      end
      OP_TRC_SGL, OP_TRC_DBL: begin
        hit = trc_ok;
        if (!aarch32_i)           code = EC_SYSREG;
        else if (op == OP_TRC_SGL) code = EC_TRC_SGL;
        else                      code = EC_TRC_DBL;
      end
      OP_OVL: begin
        hit  = has_ovl_i & ~ovl_bit_i & (el_i == 2'd0) & ~aarch32_i;
        code = EC_SYSREG;
      end
      default: begin
        hit  = 1'b0;
        code = '0;
      end
    endcase
  end

  always_comb begin
    res_o = '0;
    if (hit && !suppress_i) begin
      res_o.trap = 1'b1;
      res_o.tgt  = to_el2_i ? 2'd2 : 2'd1;
      res_o.ec   = code;
    end
  end
endmodule

// File: rtl/trap_eval.sv
module trap_eval
  import trap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_word_i,
  input  logic [EL_W-1:0]   cur_el_i,
  input  logic              aarch32_i,
  input  logic [OP_W-1:0]   op_class_i,
  input  logic              streaming_i,
  input  logic              has_vec_i,
  input  logic              has_mat_i,
  input  logic              has_trace_i,
  input  logic              has_ovl_i,
  input  logic              trace_no_el0_i,
  input  logic              el2_en_i,
  input  logic              e2h_i,
  input  logic              tge_i,
  output logic              trap_o,
  output logic [EL_W-1:0]   target_el_o,
  output logic [EC_W-1:0]   ec_o
);
  localparam logic [CTRL_W-1:0] USED = used_mask();

  logic [NUM_FLD-1:0] fld_present;
  logic [NUM_FLD-1:0] fld_trap;
  logic               to_el2;
  logic               suppress;
  trap_res_t          res_d;
  trap_res_t          res_q;
  logic               unused_bits;

  assign unused_bits = ^(ctrl_word_i & ~USED);

  always_comb begin
    fld_present          = '1;
    fld_present[FLD_VEC] = has_vec_i;
    fld_present[FLD_MAT] = has_mat_i;
  end

  for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
    localparam int LSB = fld_lsb(g);
    trap_fld_dec u_dec (
      .fld_i     (ctrl_word_i[LSB+1:LSB]),
      .present_i (fld_present[g]),
      .el_i      (cur_el_i),
      .trap_o    (fld_trap[g])
    );
  end

  trap_route u_route (
    .el_i       (cur_el_i),
    .el2_en_i   (el2_en_i),
    .e2h_i      (e2h_i),
    .tge_i      (tge_i),
    .to_el2_o   (to_el2),
    .suppress_o (suppress)
  );

  trap_arb u_arb (
    .fld_trap_i     (fld_trap),
    .op_i           (op_class_i),
    .el_i           (cur_el_i),
    .aarch32_i      (aarch32_i),
    .streaming_i    (streaming_i),
    .has_vec_i      (has_vec_i),
    .trc_bit_i      (ctrl_word_i[TRC_BIT] & has_trace_i),
    .ovl_bit_i      (ctrl_word_i[OVL_BIT]),
    .has_ovl_i      (has_ovl_i),
    .trace_no_el0_i (trace_no_el0_i),
    .to_el2_i       (to_el2),
    .suppress_i     (suppress),
    .res_o          (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else         res_q <= res_d;
  end

  assign trap_o      = res_q.trap;
  assign target_el_o = res_q.tgt;
  assign ec_o        = res_q.ec;
endmodule

// File: rtl/trap_eval_chk.sv
module trap_eval_chk
  import trap_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CTRL_W-1:0] ctrl_word_i,
  input logic [EL_W-1:0]   cur_el_i,
  input logic [OP_W-1:0]   op_class_i,
  input logic              trace_no_el0_i,
  input logic              el2_en_i,
  input logic              e2h_i,
  input logic              tge_i,
  input logic              trap_o,
  input logic [EL_W-1:0]   target_el_o,
  input logic [EC_W-1:0]   ec_o
);
  AST_FP_OPEN_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_class_i == 4'd1 && ctrl_word_i[21:20] == 2'b11) |=> !trap_o); // R1
  AST_OVL_ONLY_EL0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_class_i == 4'd8 && cur_el_i != 2'd0) |=> !trap_o); // R3
  AST_TGT_L2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (el2_en_i && tge_i) |=> (!trap_o || target_el_o == 2'd2)); // R4
  AST_TGT_L1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(el2_en_i && tge_i) |=> (!trap_o || target_el_o == 2'd1)); // R4
  AST_FP_CODE_L2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && target_el_o == 2'd2) |-> ec_o != EC_FP_L1); // R5
  AST_HOST_EL0_LIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_el_i == 2'd0 && e2h_i && tge_i) |=> !trap_o); // R6
  AST_HIGH_EL_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_el_i[1] |=> !trap_o); // R7
  AST_TRC_UNDEF_EL0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_class_i == 4'd6 || op_class_i == 4'd7) && cur_el_i == 2'd0 && trace_no_el0_i)
    |=> !trap_o); // R11
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> (target_el_o == 2'd0 && ec_o == 6'd0)); // R13
endmodule

bind trap_eval trap_eval_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ctrl_word_i    (ctrl_word_i),
  .cur_el_i       (cur_el_i),
  .op_class_i     (op_class_i),
  .trace_no_el0_i (trace_no_el0_i),
  .el2_en_i       (el2_en_i),
  .e2h_i          (e2h_i),
  .tge_i          (tge_i),
  .trap_o         (trap_o),
  .target_el_o    (target_el_o),
  .ec_o           (ec_o)
);

// File: tb/trap_eval_tb.sv
`timescale 1ns/1ps
module trap_eval_tb;
  typedef struct packed {
    logic [63:0] word;
    logic [1:0]  el;
    logic        a32;
    logic [3:0]  op;
    logic        strm, hv, hm, ht, ho, tne, el2, e2h, tge;
    logic        x_trap;
    logic [1:0]  x_tgt;
    logic [5:0]  x_ec;
  } vec_t;

  localparam int NDIR = 17;
  localparam vec_t DIR_TBL [NDIR] = '{
    '{64'h0000_0000_0010_0000, 2'd0, 1'b0, 4'd1, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd1,6'h07}, // R1 01 at L0
    '{64'h0000_0000_0010_0000, 2'd1, 1'b0, 4'd1, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,6'h00}, // R1 01 at L1
    '{64'h0000_0000_0020_0000, 2'd1, 1'b0, 4'd1, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1, 1'b1,2'd2,6'h00}, // R5 R4 to L2
    '{64'h0000_0000_1030_0000, 2'd1, 1'b1, 4'd7, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd1,6'h0C}, // R2 double
    '{64'h0000_0000_1030_0000, 2'd1, 1'b1, 4'd6, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd1,6'h05}, // R2 single
    '{64'h0000_0000_1030_0000, 2'd0, 1'b0, 4'd6, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd1,6'h18}, // R2 64-bit
    '{64'h0000_0000_1030_0000, 2'd0, 1'b0, 4'd6, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,2'd0,6'h00}, // R11
    '{64'h0000_0000_0000_0000, 2'd0, 1'b0, 4'd8, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd1,6'h18}, // R3 overlay 0
    '{64'h0000_0000_2000_0000, 2'd0, 1'b0, 4'd8, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,6'h00}, // R3 overlay 1
    '{64'h0000_0000_0000_0000, 2'd1, 1'b0, 4'd2, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd1,6'h19}, // R8 vec over fp
    '{64'h0000_0000_0003_0000, 2'd1, 1'b0, 4'd2, 1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd1,6'h1D}, // R9 streaming
    '{64'h0000_0000_0000_0000, 2'd0, 1'b0, 4'd1, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1, 1'b0,2'd0,6'h00}, // R6
    '{64'h0000_0000_0000_0000, 2'd3, 1'b0, 4'd1, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,6'h00}, // R7
    '{64'hFFFF_FFFF_EFFF_FFFF, 2'd0, 1'b0, 4'd1, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,6'h00}, // R12
    '{64'h0000_0000_0003_0000, 2'd1, 1'b0, 4'd2, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd1,6'h1D}, // R10 no vec
    '{64'h0000_0000_0000_0000, 2'd0, 1'b0, 4'd3, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,2'd1,6'h1D}, // R8 mat over fp
    '{64'h0000_0000_1000_0000, 2'd1, 1'b0, 4'd6, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,2'd0,6'h00}  // R10 no trace
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] ctrl_word_i = '0;
  logic [1:0]  cur_el_i = '0;
  logic        aarch32_i = 1'b0;
  logic [3:0]  op_class_i = '0;
  logic        streaming_i = 1'b0, has_vec_i = 1'b0, has_mat_i = 1'b0, has_trace_i = 1'b0;
  logic        has_ovl_i = 1'b0, trace_no_el0_i = 1'b0, el2_en_i = 1'b0, e2h_i = 1'b0, tge_i = 1'b0;
  logic        trap_o;
  logic [1:0]  target_el_o;
  logic [5:0]  ec_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  trap_eval u_dut (.*);

  function automatic logic lvl_hit(input logic [1:0] f, input logic [1:0] el);
    if (el == 2'd0) return f != 2'b11;
    if (el == 2'd1) return f == 2'b00 || f == 2'b10;
    return 1'b0;
  endfunction

  function automatic logic [8:0] ref_eval(input vec_t v);
    logic [1:0] fpf, vf, mf, gf;
    logic t, l2, gm;
    logic [5:0] c, fpc;
    l2  = v.el2 & v.tge;
    fpc = l2 ? 6'h00 : 6'h07;
    fpf = v.word[21:20];
    vf  = v.hv ? v.word[17:16] : 2'b00;
    mf  = v.hm ? v.word[25:24] : 2'b00;
    gm  = v.strm || !v.hv;
    gf  = gm ? mf : vf;
    t = 1'b0; c = 6'h00;
    case (v.op)
      4'd1: begin t = lvl_hit(fpf, v.el); c = fpc; end
      4'd2: if (lvl_hit(gf, v.el)) begin t = 1'b1; c = gm ? 6'h1D : 6'h19; end
            else if (lvl_hit(fpf, v.el)) begin t = 1'b1; c = fpc; end
      4'd3: if (lvl_hit(mf, v.el)) begin t = 1'b1; c = 6'h1D; end
            else if (lvl_hit(fpf, v.el)) begin t = 1'b1; c = fpc; end
      4'd4: begin t = lvl_hit(vf, v.el); c = 6'h19; end
      4'd5: begin t = lvl_hit(mf, v.el); c = 6'h1D; end
      4'd6, 4'd7: begin
        t = v.ht && v.word[28] && v.el <= 2'd1 && !(v.el == 2'd0 && v.tne);
        c = !v.a32 ? 6'h18 : (v.op == 4'd6 ? 6'h05 : 6'h0C);
      end
      4'd8: begin t = v.ho && !v.word[29] && v.el == 2'd0 && !v.a32; c = 6'h18; end
      default: t = 1'b0;
    endcase
    if (v.el >= 2'd2 || (v.el == 2'd0 && v.e2h && v.tge)) t = 1'b0;
    return t ? {1'b1, (l2 ? 2'd2 : 2'd1), c} : 9'd0;
  endfunction

  task automatic drive(input vec_t v);
    ctrl_word_i = v.word; cur_el_i = v.el; aarch32_i = v.a32; op_class_i = v.op;
    streaming_i = v.strm; has_vec_i = v.hv; has_mat_i = v.hm; has_trace_i = v.ht;
    has_ovl_i = v.ho; trace_no_el0_i = v.tne; el2_en_i = v.el2; e2h_i = v.e2h; tge_i = v.tge;
  endtask

  task automatic cmp(input string tag, input logic [8:0] exp);
    checks++;
    if ({trap_o, target_el_o, ec_o} !== exp) begin
      errors++;
      $display("FAIL %s: got trap=%0b tgt=%0d ec=%02h, exp trap=%0b tgt=%0d ec=%02h",
               tag, trap_o, target_el_o, ec_o, exp[8], exp[7:6], exp[5:0]);
    end
  endtask

  task automatic run_vec(input string tag, input vec_t v, input logic [8:0] exp);
    drive(v);
    @(posedge clk_i);
    @(negedge clk_i);
    cmp(tag, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not complete, exp completion");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    vec_t s;
    // R13: reset holds outputs at zero even with a trapping input
    drive(DIR_TBL[0]);
    repeat (3) @(negedge clk_i);
    cmp("R13 reset", 9'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NDIR; i++)
      run_vec($sformatf("directed %0d", i), DIR_TBL[i],
              {DIR_TBL[i].x_trap, DIR_TBL[i].x_tgt, DIR_TBL[i].x_ec});

    // R13: one-cycle latency
    run_vec("R13 latency set", DIR_TBL[0], {1'b1, 2'd1, 6'h07});
    drive(DIR_TBL[12]);
    #2;
    cmp("R13 latency hold", {1'b1, 2'd1, 6'h07});
    @(posedge clk_i);
    @(negedge clk_i);
    cmp("R13 latency update", 9'd0);

    // R1 R2 R3 R4 R5 R8 R9 R10 R12: sweep every field value, level and class
    lfsr = 16'hACE1;
    for (int f = 0; f < 256; f++) begin
      for (int el = 0; el < 4; el++) begin
        for (int op = 0; op < 9; op++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          s = '0;
          s.word = (64'hA5A5_5A5A_C0C0_A5A5 & ~64'h0000_0000_3333_0000)
                 | (64'(f[1:0]) << 20) | (64'(f[3:2]) << 16) | (64'(f[5:4]) << 24)
                 | (64'(f[6]) << 28) | (64'(f[7]) << 29);
          s.el   = 2'(el);
          s.op   = 4'(op);
          s.strm = lfsr[0];
          s.hv   = lfsr[1] | lfsr[9];
          s.hm   = lfsr[2] | lfsr[10];
          s.ht   = lfsr[3] | lfsr[11];
          s.ho   = lfsr[4] | lfsr[12];
          s.tne  = lfsr[5] & lfsr[13];
          s.el2  = lfsr[6];
          s.e2h  = lfsr[7];
          s.tge  = lfsr[8];
          s.a32  = lfsr[14];
          run_vec("sweep R1/R8", s, ref_eval(s));
        end
      end
    end
    finish_run();
  end
endmodule